// File: doc/BRIEF.md
# Slope-Compensated Current Reference Generator

This block forms the digital part of the outer voltage loop of a peak-current-mode buck controller. Software writes a target output code into a setpoint register. The block also captures the most recent raw sample of the output voltage that the ADC offers with a valid pulse. Each switching period starts with a cycle-start strobe. On that strobe the block subtracts the captured sample from the setpoint. It clamps a negative result to zero and loads the result into a down counter.

During the period the counter falls by one step every `step_div + 1` system clocks and stops at zero. Its value is driven out as the DAC code that sets the threshold of the current comparator. The falling threshold provides the slope compensation, and `step_div` sets how steep it is. Because the setpoint is read only at the strobe, a write from software changes nothing until the next period begins.

Top module: `slope_ref_gen`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `dac_code` is 0. The setpoint and the captured sample both reset to 0.
- R2: A write through `sp_wr_en`/`sp_wr_data` changes `dac_code` only at the next `cyc_start`. Between strobes the code never rises.
- R3: At the clock edge that samples `cyc_start` high, the counter loads setpoint minus captured sample. `dac_code` shows that value from the next cycle.
- R4: When the captured sample is larger than the setpoint, the loaded value is 0.
- R5: After a load, the counter drops by exactly 1 after each further run of `step_div + 1` clock edges. After k edges it reads max(load − floor(k/(step_div+1)), 0).
- R6: The counter holds at 0 once it reaches 0 and never wraps to the all-ones code.
- R7: `adc_data` is captured only on cycles with `adc_valid` high. At other times it is ignored.
- R8: A setpoint write or ADC sample in the same cycle as `cyc_start` is not used by that strobe's load. It is used by the following strobe.
- R9: A `cyc_start` in the middle of a ramp reloads the counter and restarts the step prescaler from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sp_wr_en | input | 1 | Setpoint register write enable |
| sp_wr_data | input | DATA_W | Setpoint value to write |
| step_div | input | DIV_W | Clocks per decrement, minus one |
| adc_valid | input | 1 | Marks `adc_data` as a new sample |
| adc_data | input | DATA_W | Raw ADC output-voltage code |
| cyc_start | input | 1 | One-cycle strobe starting a switching period |
| dac_code | output | DATA_W | Current-threshold code for the DAC |

## Verification
Two functions can fall in the same cycle: the period-start load, and an update of its operands (a setpoint write, an ADC valid pulse, or both). The bench raises `cyc_start`, `sp_wr_en` and `adc_valid` on one clock edge. It expects the code after that edge to come from the old operands, and the code after the following strobe to come from the new ones. A second collision is a strobe that arrives partway into a prescaler interval. That case is judged by when the first decrement after the reload lands.

// File: rtl/slope_pkg.sv
package slope_pkg;

    localparam int unsigned DEF_DATA_W = 8;
    localparam int unsigned DEF_DIV_W  = 8;

    // Per-cycle action selected for the ramp counter
    typedef enum logic [1:0] {
        RAMP_HOLD = 2'd0,
        RAMP_LOAD = 2'd1,
        RAMP_STEP = 2'd2
    } ramp_op_e;

    function automatic logic is_zero8(input logic [7:0] v);
        return v == 8'd0;
    endfunction

endpackage

// File: rtl/slope_capture_reg.sv
module slope_capture_reg #(
    parameter int unsigned W = slope_pkg::DEF_DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= d;
        end
    end

endmodule

// File: rtl/slope_err_sat.sv
module slope_err_sat #(
    parameter int unsigned W = slope_pkg::DEF_DATA_W
) (
    input  logic [W-1:0] target,
    input  logic [W-1:0] measured,
    output logic [W-1:0] err
);

    localparam int unsigned XW = W + 1;

    logic [XW-1:0] diff;

    always_comb begin
        diff = {1'b0, target} - {1'b0, measured};
        // borrow out means measured exceeded target: clamp
        if (diff[XW-1]) begin
            err = '0;
        end else begin
            err = diff[W-1:0];
        end
    end

endmodule

// File: rtl/slope_ramp.sv
module slope_ramp #(
    parameter int unsigned W     = slope_pkg::DEF_DATA_W,
    parameter int unsigned DIV_W = slope_pkg::DEF_DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [W-1:0]     load_val,
    input  logic [DIV_W-1:0] step_div,
    output logic [W-1:0]     level
);
    import slope_pkg::*;

    typedef struct packed {
        logic [W-1:0]     level;
        logic [DIV_W-1:0] tick;
    } ramp_state_t;

    ramp_state_t cur, nxt;
    ramp_op_e    op;
    logic        at_floor;

    assign at_floor = (cur.level == '0);

    always_comb begin
        if (load) begin
            op = RAMP_LOAD;
        end else if (!at_floor && (cur.tick >= step_div)) begin
            op = RAMP_STEP;
        end else begin
            op = RAMP_HOLD;
        end
    end

    always_comb begin
        nxt = cur;
        unique case (op)
            RAMP_LOAD: begin
                nxt.level = load_val;
                nxt.tick  = '0;
            end
            RAMP_STEP: begin
                nxt.level = cur.level - 1'b1;
                nxt.tick  = '0;
            end
            default: begin
                nxt.tick = at_floor ? '0 : cur.tick + 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else begin
            cur <= nxt;
        end
    end

    assign level = cur.level;

endmodule

// File: rtl/slope_ref_gen.sv
module slope_ref_gen #(
    parameter int unsigned DATA_W = slope_pkg::DEF_DATA_W,
    parameter int unsigned DIV_W  = slope_pkg::DEF_DIV_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sp_wr_en,
    input  logic [DATA_W-1:0] sp_wr_data,
    input  logic [DIV_W-1:0]  step_div,
    input  logic              adc_valid,
    input  logic [DATA_W-1:0] adc_data,
    input  logic              cyc_start,
    output logic [DATA_W-1:0] dac_code
);

    logic [DATA_W-1:0] setpoint_q;
    logic [DATA_W-1:0] sample_q;
    logic [DATA_W-1:0] err_clamped;

    slope_capture_reg #(.W(DATA_W)) sp_reg_i (
        .clk (clk),
        .rst (rst),
        .we  (sp_wr_en),
        .d   (sp_wr_data),
        .q   (setpoint_q)
    );

    slope_capture_reg #(.W(DATA_W)) sample_reg_i (
        .clk (clk),
        .rst (rst),
        .we  (adc_valid),
        .d   (adc_data),
        .q   (sample_q)
    );

    slope_err_sat #(.W(DATA_W)) err_i (
        .target   (setpoint_q),
        .measured (sample_q),
        .err      (err_clamped)
    );

    slope_ramp #(.W(DATA_W), .DIV_W(DIV_W)) ramp_i (
        .clk      (clk),
        .rst      (rst),
        .load     (cyc_start),
        .load_val (err_clamped),
        .step_div (step_div),
        .level    (dac_code)
    );

endmodule

// File: rtl/slope_ref_gen_chk.sv
module slope_ref_gen_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DIV_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cyc_start,
    input logic [DIV_W-1:0]  step_div,
    input logic [DATA_W-1:0] dac_code
);

    // R1: code is zero right after reset
    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> dac_code == '0);

    // R2: without a strobe the code never rises
    a_r2_no_midcycle_rise: assert property (@(posedge clk) disable iff (rst)
        !cyc_start |=> dac_code <= $past(dac_code));

    // R5: without a strobe the code moves by at most one step
    a_r5_single_step: assert property (@(posedge clk) disable iff (rst)
        !cyc_start |=> (dac_code == $past(dac_code))
                    || (dac_code == DATA_W'($past(dac_code) - 1'b1)));

    // R5: with the fastest slope a nonzero code falls every clock
    a_r5_fast_slope: assert property (@(posedge clk) disable iff (rst)
        (step_div == '0 && !cyc_start && dac_code != '0)
            |=> dac_code == DATA_W'($past(dac_code) - 1'b1));

    // R6: zero is sticky until the next strobe
    a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (!cyc_start && dac_code == '0) |=> dac_code == '0);

endmodule

bind slope_ref_gen slope_ref_gen_chk #(.DATA_W(DATA_W), .DIV_W(DIV_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .cyc_start (cyc_start),
    .step_div  (step_div),
    .dac_code  (dac_code)
);

// File: tb/slope_ref_gen_tb_top.sv
module slope_ref_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    typedef struct packed {
        logic [7:0] sp;
        logic [7:0] adc;
        logic [7:0] div;
        logic [7:0] wait_n;
        logic [7:0] expect_code;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VEC [NVEC] = '{
        '{8'd100, 8'd40, 8'd0, 8'd0,  8'd60 },   // R3
        '{8'd100, 8'd40, 8'd0, 8'd10, 8'd50 },   // R5
        '{8'd200, 8'd50, 8'd3, 8'd12, 8'd147},   // R5
        '{8'd50,  8'd80, 8'd0, 8'd0,  8'd0  },   // R4
        '{8'd10,  8'd5,  8'd0, 8'd20, 8'd0  },   // R6
        '{8'd255, 8'd0,  8'd9, 8'd25, 8'd253},   // R5
        '{8'd30,  8'd30, 8'd0, 8'd3,  8'd0  },   // R4
        '{8'd20,  8'd10, 8'd1, 8'd7,  8'd7  }    // R5
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sp_wr_en = 1'b0;
    logic [DW-1:0] sp_wr_data = '0;
    logic [7:0]    step_div = '0;
    logic          adc_valid = 1'b0;
    logic [DW-1:0] adc_data = '0;
    logic          cyc_start = 1'b0;
    logic [DW-1:0] dac_code;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slope_ref_gen #(.DATA_W(DW), .DIV_W(8)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .sp_wr_en   (sp_wr_en),
        .sp_wr_data (sp_wr_data),
        .step_div   (step_div),
        .adc_valid  (adc_valid),
        .adc_data   (adc_data),
        .cyc_start  (cyc_start),
        .dac_code   (dac_code)
    );

    task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] want);
        n_checks++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s: dac_code=%0d expected=%0d", req, got, want);
        end
    endtask

    // write setpoint and present one ADC sample in one cycle
    task automatic prime(input logic [7:0] sp, input logic [7:0] adc, input logic [7:0] dv);
        @(negedge clk);
        sp_wr_en = 1'b1; sp_wr_data = sp;
        adc_valid = 1'b1; adc_data = adc;
        step_div = dv;
        @(negedge clk);
        sp_wr_en = 1'b0; adc_valid = 1'b0;
    endtask

    // one-cycle strobe; returns at the negedge after the load edge
    task automatic strobe();
        cyc_start = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait_n(4);
        check("R1 during reset", dac_code, 8'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", dac_code, 8'd0);
        // R1: a strobe with reset operands loads 0
        strobe();
        check("R1 reset operands", dac_code, 8'd0);

        for (int v = 0; v < NVEC; v++) begin
            prime(VEC[v].sp, VEC[v].adc, VEC[v].div);
            strobe();
            wait_n(int'(VEC[v].wait_n));
            check($sformatf("R3/R4/R5/R6 vector %0d", v), dac_code, VEC[v].expect_code);
        end

        // R2: mid-cycle setpoint write has no effect until the next strobe
        prime(8'd120, 8'd20, 8'd255);
        strobe();
        check("R2 base load", dac_code, 8'd100);
        sp_wr_en = 1'b1; sp_wr_data = 8'd250;
        @(negedge clk);
        sp_wr_en = 1'b0;
        wait_n(3);
        check("R2 mid-cycle write ignored", dac_code, 8'd100);
        strobe();
        check("R2 write applied at strobe", dac_code, 8'd230);

        // R7: adc_data without valid is ignored
        adc_data = 8'd99;
        wait_n(2);
        strobe();
        check("R7 invalid sample ignored", dac_code, 8'd230);

        // R8: write + sample + strobe in the same cycle
        sp_wr_en = 1'b1; sp_wr_data = 8'd60;
        adc_valid = 1'b1; adc_data = 8'd10;
        cyc_start = 1'b1;
        @(negedge clk);
        sp_wr_en = 1'b0; adc_valid = 1'b0; cyc_start = 1'b0;
        check("R8 same-cycle uses old operands", dac_code, 8'd230);
        strobe();
        check("R8 next strobe uses new operands", dac_code, 8'd50);

        // R9: strobe mid-interval restarts the prescaler
        step_div = 8'd3;
        strobe();
        wait_n(2);
        check("R9 no step before interval", dac_code, 8'd50);
        wait_n(2);
        check("R9 first step", dac_code, 8'd49);
        wait_n(2);
        strobe();
        check("R9 reload value", dac_code, 8'd50);
        wait_n(3);
        check("R9 prescaler restarted", dac_code, 8'd50);
        wait_n(1);
        check("R9 step after full interval", dac_code, 8'd49);

        // R6: long hold at zero, no wrap
        prime(8'd5, 8'd0, 8'd0);
        strobe();
        wait_n(40);
        check("R6 held at zero", dac_code, 8'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule